// File: doc/BRIEF.md
# Dual-Pair Cross-Checking Bus Receiver

This block is a listen-only front end for a redundant backplane bus. The bus has four serial lanes in two pairs, A and B, and each pair has an x lane and a y lane. Every lane has its own clock line and two data lines. The block oversamples all twelve lines with the fast system clock. It detects rising edges of each lane clock after a synchronizer and shifts two bits per edge into a per-lane word.

A transfer window begins with a one-cycle `win_start`, which also samples the acceptance policy for that window. At the end of the window the four lane words are compared in four pairs: the two lanes inside pair A, the two lanes inside pair B, and the two diagonal pairings between A and B. The comparison results and the set of lanes that delivered a whole word decide whether a word is accepted.

Integrity policy requires full agreement before it accepts a word. Availability policy accepts the first trustworthy source in a fixed order of preference. A lane that shows no clock edge before the window timeout is latched as faulty until software clears it. The block has no outputs toward the bus.

Top module: `xcheck_bus_rx`

## Requirements
- R1: Lane index 0 is A-x, 1 is A-y, 2 is B-x and 3 is B-y. Lane i takes `lane_clk[i]` and the data bits `lane_dat[2i+1:2i]`. On each synchronized rising edge of its clock, a lane shifts in its two data bits, with bit 2i+1 as the more significant bit. The first pair lands in the top bits of the word. After 16 edges the lane holds a complete 32-bit word and counts as valid for the window.
- R2: Lane clock edges after the 16th edge of a window are ignored until the next `win_start`. The extra data never alters the delivered word.
- R3: `mismatch` bits are: bit0 A-x≠A-y, bit1 B-x≠B-y, bit2 A-x≠B-y, bit3 A-y≠B-x. A bit is 1 only when both of its lanes are valid and their words differ. The vector is updated at each decision and held until the next decision.
- R4: Under integrity policy (`win_integrity`=1 at `win_start`), a word is accepted only if all four lanes are valid, A-x=A-y, B-x=B-y and A-x=B-y. The accepted word is A-x.
- R5: Under availability policy (`win_integrity`=0), the accepted word is chosen by the first condition that holds, in this order:
  1. A-x, when pair A is valid and equal.
  2. B-x, when pair B is valid and equal.
  3. A-x, when A-x and B-y are valid and equal.
  4. A-y, when A-y and B-x are valid and equal.

  If none of these holds, the word is rejected.
- R6: A rejected decision raises `word_err` for exactly one cycle, with no `word_stb`, and leaves `word_out` unchanged.
- R7: Each window produces exactly one decision. An accepted word raises `word_stb` for exactly one cycle, with `word_out` valid in that same cycle.
- R8: The decision is made as soon as all four lanes hold complete words. Otherwise it is made at the timeout, `tmo_limit`+1 cycles after `win_start`. A lane without a complete word at that point is invalid.
- R9: A lane with no clock edge between `win_start` and the timeout sets its `lane_fault` bit. The bit stays set across later windows until the matching `fault_clr` bit is pulsed.
- R10: The policy is sampled only at `win_start`. Changing `win_integrity` later in the window has no effect on that window's decision.
- R11: After reset, `word_out`, `word_stb`, `word_err`, `mismatch` and `lane_fault` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast oversampling system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lane_clk | input | 4 | Raw clock line of each lane |
| lane_dat | input | 8 | Raw data lines, two per lane |
| win_start | input | 1 | One-cycle pulse opening a window |
| win_integrity | input | 1 | Policy select sampled at `win_start` (1 = integrity) |
| tmo_limit | input | 12 | Window timeout in system cycles |
| fault_clr | input | 4 | Per-lane clear of the sticky fault bit |
| word_out | output | 32 | Last accepted word |
| word_stb | output | 1 | One-cycle strobe for an accepted word |
| word_err | output | 1 | One-cycle strobe for a rejected window |
| mismatch | output | 4 | Result of the four comparisons at the last decision |
| lane_fault | output | 4 | Sticky per-lane no-clock fault |

## Verification
A fault in a lane's beat counter or shift register shows up in the decision of the same window. It appears as a wrong `word_out`, a spurious `mismatch` bit, or a `word_err` where agreement was expected. A broken window or timeout state shows up as a missing decision, a doubled decision or a decision at the wrong time, all within `tmo_limit`+2 cycles of `win_start`. Corrupted fault tracking appears in `lane_fault` right after the timeout of the window that exercised it, and it persists into the following windows.

// File: rtl/qlv_pkg.sv
package qlv_pkg;
   typedef enum logic {
      POL_AVAIL = 1'b0,
      POL_INTEG = 1'b1
   } policy_e;

   localparam int NUM_LANES = 4;
   localparam int LN_AX     = 0;
   localparam int LN_AY     = 1;
   localparam int LN_BX     = 2;
   localparam int LN_BY     = 3;
endpackage

// File: rtl/qlv_lane_deser.sv
module qlv_lane_deser #(
   parameter int WORD_W      = 32,
   parameter int DAT_W       = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              win_start,
   input  logic              tmo_expire,
   input  logic              lane_clk,
   input  logic [DAT_W-1:0]  lane_dat,
   input  logic              fault_clr,
   output logic [WORD_W-1:0] word,
   output logic              done,
   output logic              seen,
   output logic              fault
);
   localparam int BEATS = WORD_W / DAT_W;
   localparam int CNT_W = (BEATS > 1) ? $clog2(BEATS) : 1;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0]            ck_s;
   logic [SYNC_STAGES-1:0][DAT_W-1:0] dt_s;
   logic                              ck_last;
   logic                              rise;
   logic [CNT_W-1:0]                  beat;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ck_s    <= '0;
         dt_s    <= '0;
         ck_last <= 1'b0;
      end else begin
         ck_s    <= {ck_s[SYNC_STAGES-2:0], lane_clk};
         dt_s    <= {dt_s[SYNC_STAGES-2:0], lane_dat};
         ck_last <= ck_s[SYNC_STAGES-1];
      end
   end

   assign rise = ck_s[SYNC_STAGES-1] & ~ck_last;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         word <= '0;
         beat <= '0;
         done <= 1'b0;
         seen <= 1'b0;
      end else if (win_start) begin
         word <= '0;
         beat <= '0;
         done <= 1'b0;
         seen <= 1'b0;
      end else if (rise && !done) begin
         seen <= 1'b1;
         word <= {word[WORD_W-DAT_W-1:0], dt_s[SYNC_STAGES-1]};
         beat <= beat + 1'b1;
         if (beat == CNT_W'(BEATS - 1)) begin
            done <= 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fault <= 1'b0;
      end else if (tmo_expire && !seen) begin
         fault <= 1'b1;
      end else if (fault_clr) begin
         fault <= 1'b0;
      end
   end

   // R1
   done_needs_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> seen);

   // R2
   beat_parked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (beat == '0));

   // R2
   word_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !win_start) |=> $stable(word));
endmodule

// File: rtl/qlv_win_timer.sv
module qlv_win_timer #(
   parameter int TMO_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             win_start,
   input  logic [TMO_W-1:0] tmo_limit,
   output logic             tmo_expire
);
   logic             running;
   logic [TMO_W-1:0] cnt;

   assign tmo_expire = running && (cnt == tmo_limit);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         running <= 1'b0;
         cnt     <= '0;
      end else if (win_start) begin
         running <= 1'b1;
         cnt     <= '0;
      end else if (tmo_expire) begin
         running <= 1'b0;
      end else if (running) begin
         cnt <= cnt + 1'b1;
      end
   end

   // R8
   expire_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tmo_expire && !win_start) |=> !tmo_expire);
endmodule

// File: rtl/qlv_xvote.sv
module qlv_xvote
   import qlv_pkg::*;
#(
   parameter int WORD_W = 32
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            win_start,
   input  policy_e                         pol,
   input  logic                            tmo_expire,
   input  logic [NUM_LANES-1:0][WORD_W-1:0] lane_word,
   input  logic [NUM_LANES-1:0]            lane_done,
   output logic [WORD_W-1:0]               word_out,
   output logic                            word_stb,
   output logic                            word_err,
   output logic [3:0]                      mismatch
);
   logic        busy;
   policy_e     pol_q;
   logic        decide;
   logic        eq_a, eq_b, eq_d1, eq_d2;
   logic        ok_a, ok_b, ok_d1, ok_d2;
   logic        acc;
   logic [WORD_W-1:0] sel;
   logic [3:0]  mm;

   assign eq_a  = lane_word[LN_AX] == lane_word[LN_AY];
   assign eq_b  = lane_word[LN_BX] == lane_word[LN_BY];
   assign eq_d1 = lane_word[LN_AX] == lane_word[LN_BY];
   assign eq_d2 = lane_word[LN_AY] == lane_word[LN_BX];

   assign ok_a  = lane_done[LN_AX] & lane_done[LN_AY] & eq_a;
   assign ok_b  = lane_done[LN_BX] & lane_done[LN_BY] & eq_b;
   assign ok_d1 = lane_done[LN_AX] & lane_done[LN_BY] & eq_d1;
   assign ok_d2 = lane_done[LN_AY] & lane_done[LN_BX] & eq_d2;

   assign mm[0] = lane_done[LN_AX] & lane_done[LN_AY] & ~eq_a;
   assign mm[1] = lane_done[LN_BX] & lane_done[LN_BY] & ~eq_b;
   assign mm[2] = lane_done[LN_AX] & lane_done[LN_BY] & ~eq_d1;
   assign mm[3] = lane_done[LN_AY] & lane_done[LN_BX] & ~eq_d2;

   always_comb begin
      acc = 1'b0;
      sel = lane_word[LN_AX];
      if (pol_q == POL_INTEG) begin
         acc = ok_a & ok_b & ok_d1;
      end else if (ok_a) begin
         acc = 1'b1;
      end else if (ok_b) begin
         acc = 1'b1;
         sel = lane_word[LN_BX];
      end else if (ok_d1) begin
         acc = 1'b1;
      end else if (ok_d2) begin
         acc = 1'b1;
         sel = lane_word[LN_AY];
      end
   end

   assign decide = busy & ((&lane_done) | tmo_expire);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         pol_q    <= POL_AVAIL;
         word_out <= '0;
         word_stb <= 1'b0;
         word_err <= 1'b0;
         mismatch <= '0;
      end else if (win_start) begin
         busy     <= 1'b1;
         pol_q    <= pol;
         word_stb <= 1'b0;
         word_err <= 1'b0;
      end else begin
         word_stb <= decide & acc;
         word_err <= decide & ~acc;
         if (decide) begin
            busy     <= 1'b0;
            mismatch <= mm;
            if (acc) begin
               word_out <= sel;
            end
         end
      end
   end

   // R6
   stb_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(word_stb && word_err));

   // R7
   stb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      word_stb |=> !word_stb);

   // R7
   result_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (word_stb || word_err) |-> $past(busy));

   // R4
   integ_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (word_stb && pol_q == POL_INTEG) |-> (mismatch == 4'b0000));

   // R6
   err_holds_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      word_err |-> $stable(word_out));
endmodule

// File: rtl/xcheck_bus_rx.sv
module xcheck_bus_rx #(
   parameter int WORD_W      = 32,
   parameter int DAT_W       = 2,
   parameter int SYNC_STAGES = 2,
   parameter int TMO_W       = 12
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [3:0]             lane_clk,
   input  logic [4*DAT_W-1:0]     lane_dat,
   input  logic                   win_start,
   input  logic                   win_integrity,
   input  logic [TMO_W-1:0]       tmo_limit,
   input  logic [3:0]             fault_clr,
   output logic [WORD_W-1:0]      word_out,
   output logic                   word_stb,
   output logic                   word_err,
   output logic [3:0]             mismatch,
   output logic [3:0]             lane_fault
);
   import qlv_pkg::*;

   if (WORD_W % DAT_W != 0) begin : g_bad_width
      $error("WORD_W must be a multiple of DAT_W");
   end
   if (WORD_W <= DAT_W) begin : g_bad_short
      $error("WORD_W must exceed DAT_W");
   end

   logic                             tmo_expire;
   logic [NUM_LANES-1:0][WORD_W-1:0] lane_word;
   logic [NUM_LANES-1:0]             lane_done;
   logic [NUM_LANES-1:0]             lane_seen;

   qlv_win_timer #(.TMO_W(TMO_W)) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .win_start  (win_start),
      .tmo_limit  (tmo_limit),
      .tmo_expire (tmo_expire)
   );

   for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
      qlv_lane_deser #(
         .WORD_W      (WORD_W),
         .DAT_W       (DAT_W),
         .SYNC_STAGES (SYNC_STAGES)
      ) u_deser (
         .clk        (clk),
         .rst_n      (rst_n),
         .win_start  (win_start),
         .tmo_expire (tmo_expire),
         .lane_clk   (lane_clk[g]),
         .lane_dat   (lane_dat[g*DAT_W +: DAT_W]),
         .fault_clr  (fault_clr[g]),
         .word       (lane_word[g]),
         .done       (lane_done[g]),
         .seen       (lane_seen[g]),
         .fault      (lane_fault[g])
      );

      // R9
      fault_after_tmo_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(lane_fault[g]) |-> ($past(tmo_expire) && !$past(lane_seen[g])));
   end

   qlv_xvote #(.WORD_W(WORD_W)) u_vote (
      .clk        (clk),
      .rst_n      (rst_n),
      .win_start  (win_start),
      .pol        (policy_e'(win_integrity)),
      .tmo_expire (tmo_expire),
      .lane_word  (lane_word),
      .lane_done  (lane_done),
      .word_out   (word_out),
      .word_stb   (word_stb),
      .word_err   (word_err),
      .mismatch   (mismatch)
   );
endmodule

// File: tb/tb_xcheck_bus_rx.sv
module tb_xcheck_bus_rx;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  lane_clk = '0;
   logic [7:0]  lane_dat = '0;
   logic        win_start = 1'b0;
   logic        win_integrity = 1'b0;
   logic [11:0] tmo_limit = 12'd150;
   logic [3:0]  fault_clr = '0;
   logic [31:0] word_out;
   logic        word_stb, word_err;
   logic [3:0]  mismatch, lane_fault;

   int checks = 0, errors = 0, ev_cnt = 0;
   logic prev_stb = 1'b0, prev_err = 1'b0;
   logic last_acc = 1'b0;
   logic [31:0] last_word = '0;
   logic [3:0]  exp_fault = '0;
   logic [31:0] exp_last = '0;
   bit done_flag = 0;

   always #10 clk = ~clk;

   xcheck_bus_rx dut (
      .clk(clk), .rst_n(rst_n), .lane_clk(lane_clk), .lane_dat(lane_dat),
      .win_start(win_start), .win_integrity(win_integrity), .tmo_limit(tmo_limit),
      .fault_clr(fault_clr), .word_out(word_out), .word_stb(word_stb),
      .word_err(word_err), .mismatch(mismatch), .lane_fault(lane_fault)
   );

   task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         if (word_stb && prev_stb) chk(1'b0, "R7 strobe longer than one cycle", 32'd1, 32'd0);
         if (word_err && prev_err) chk(1'b0, "R6 error longer than one cycle", 32'd1, 32'd0);
         if (word_stb || word_err) begin
            ev_cnt++;
            last_acc  = word_stb;
            last_word = word_out;
         end
      end
      prev_stb = word_stb;
      prev_err = word_err;
   end

   function automatic void exp_vote(input logic [3:0][31:0] w, input logic [3:0] v, input logic integ,
                                    output logic acc, output logic [31:0] wd, output logic [3:0] mm);
      mm[0] = v[0] & v[1] & (w[0] != w[1]);
      mm[1] = v[2] & v[3] & (w[2] != w[3]);
      mm[2] = v[0] & v[3] & (w[0] != w[3]);
      mm[3] = v[1] & v[2] & (w[1] != w[2]);
      acc = 1'b0;
      wd  = w[0];
      if (integ) begin
         acc = (&v) && (w[0] == w[1]) && (w[2] == w[3]) && (w[0] == w[3]);
      end else if (v[0] && v[1] && w[0] == w[1]) begin
         acc = 1'b1;
      end else if (v[2] && v[3] && w[2] == w[3]) begin
         acc = 1'b1; wd = w[2];
      end else if (v[0] && v[3] && w[0] == w[3]) begin
         acc = 1'b1;
      end else if (v[1] && v[2] && w[1] == w[2]) begin
         acc = 1'b1; wd = w[1];
      end
   endfunction

   task automatic run_window(input logic [3:0][31:0] w, input logic [3:0] present,
                             input int beats, input logic integ, input string tag);
      int start_ev;
      int cyc;
      logic acc;
      logic [31:0] wd;
      logic [3:0] mm;
      logic [3:0] v;
      v = (beats >= 16) ? present : 4'b0000;
      exp_vote(w, v, integ, acc, wd, mm);
      start_ev = ev_cnt;
      @(negedge clk);
      win_start = 1'b1;
      win_integrity = integ;
      @(negedge clk);
      win_start = 1'b0;
      win_integrity = ~integ;   // R10: later changes must be ignored
      cyc = 1;
      for (int b = 0; b < beats; b++) begin
         for (int i = 0; i < 4; i++) begin
            if (b < 16) lane_dat[2*i +: 2] = w[i][31-2*b -: 2];
            else        lane_dat[2*i +: 2] = 2'($urandom);
         end
         repeat (3) @(negedge clk);
         lane_clk = present;
         repeat (3) @(negedge clk);
         lane_clk = '0;
         cyc += 6;
      end
      while (ev_cnt == start_ev && cyc < 300) begin
         @(negedge clk);
         cyc++;
      end
      chk(ev_cnt == start_ev + 1, {"R8 decision made ", tag}, 32'(ev_cnt - start_ev), 32'd1);
      chk(last_acc == acc, {"R4/R5 accept outcome ", tag}, {31'd0, last_acc}, {31'd0, acc});
      if (acc) begin
         chk(last_word == wd, {"R1/R5 accepted word ", tag}, last_word, wd);
         exp_last = wd;
      end else begin
         chk(last_word == exp_last, {"R6 word held on reject ", tag}, last_word, exp_last);
      end
      chk(mismatch == mm, {"R3 mismatch vector ", tag}, {28'd0, mismatch}, {28'd0, mm});
      while (cyc < 200) begin
         @(negedge clk);
         cyc++;
      end
      chk(ev_cnt == start_ev + 1, {"R7 single decision ", tag}, 32'(ev_cnt - start_ev), 32'd1);
      if (beats == 0) exp_fault |= 4'b1111;
      else            exp_fault |= ~present;
      chk(lane_fault == exp_fault, {"R9 sticky fault ", tag}, {28'd0, lane_fault}, {28'd0, exp_fault});
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done_flag) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [3:0][31:0] w;
      logic [31:0] base;
      void'($urandom(32'd2024));
      repeat (4) @(negedge clk);
      // R11 reset state
      chk(word_out == 0 && !word_stb && !word_err, "R11 reset outputs", word_out, 32'd0);
      chk(mismatch == 0 && lane_fault == 0, "R11 reset status", {24'd0, mismatch, lane_fault}, 32'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      base = 32'hC35A_96E1;
      w = {base, base, base, base};
      run_window(w, 4'b1111, 16, 1'b1, "R4 all agree integrity");
      w = {base, base, base, 32'h1234_5678};
      run_window(w, 4'b1111, 16, 1'b1, "R4 A-x corrupt integrity");
      run_window(w, 4'b1111, 16, 1'b0, "R5 A-x corrupt availability");
      // A-x!=A-y, B-x!=B-y, A-x!=B-y, A-y==B-x: diagonal two picks A-y
      w = {32'h0000_0003, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 32'h0000_0001};
      run_window(w, 4'b1111, 16, 1'b0, "R5 second diagonal");
      // diagonal one: A-x==B-y
      w = {32'h5555_0000, 32'h0000_0002, 32'h0000_0001, 32'h5555_0000};
      run_window(w, 4'b1111, 16, 1'b0, "R5 first diagonal");
      w = {base, base, ~base, ~base};
      run_window(w, 4'b1111, 16, 1'b0, "R5 pair A preferred");
      w = {base, base, base, base};
      run_window(w, 4'b1111, 18, 1'b0, "R2 extra edges ignored");
      run_window(w, 4'b1100, 16, 1'b1, "R9 pair A silent integrity");
      run_window(w, 4'b1100, 16, 1'b0, "R9 pair A silent availability");
      run_window(w, 4'b1111, 8, 1'b0, "R8 short words timeout");

      @(negedge clk);
      fault_clr = 4'b0001;
      @(negedge clk);
      fault_clr = 4'b0000;
      exp_fault = 4'b0010;
      @(negedge clk);
      chk(lane_fault == exp_fault, "R9 fault clear", {28'd0, lane_fault}, {28'd0, exp_fault});
      @(negedge clk);
      fault_clr = 4'b1111;
      @(negedge clk);
      fault_clr = 4'b0000;
      exp_fault = 4'b0000;
      @(negedge clk);
      chk(lane_fault == 4'b0000, "R9 fault clear all", {28'd0, lane_fault}, 32'd0);

      for (int n = 0; n < 40; n++) begin
         logic [3:0] pres;
         base = $urandom;
         for (int i = 0; i < 4; i++) begin
            w[i] = base;
            if ($urandom_range(0, 3) == 0) w[i] = base ^ (32'd1 << $urandom_range(0, 31));
         end
         pres = ($urandom_range(0, 4) == 0) ? 4'($urandom) : 4'b1111;
         run_window(w, pres, 16, 1'($urandom), "random window");
      end

      done_flag = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule